// File: doc/BRIEF.md
# Legacy Paravirtual Queue Register File

This block is the I/O-mapped register window of a legacy paravirtual PCI function. Software reads and writes it through a single-beat access port. The window holds the feature handshake, the queue selector, the per-queue page frame, the fixed queue size, the queue kick, the device status byte and the interrupt status byte. Offsets at or above the common area are passed on unchanged, rebased to zero, to a device-specific configuration port.

For every queue, the block keeps the page frame number that software programmed. From that single number it derives three ring base addresses: the descriptor table, the available ring and the used ring. The queue engines outside the block consume these addresses. They also receive one-cycle pulses for a device reset, a driver-ready event and a kick on each queue. Interrupt causes from the engines are collected into the status byte, and that byte drives the interrupt line until software reads it.

Register offsets (byte addresses, data right-aligned on the 32-bit bus): 0x00 offered features, 0x04 accepted features, 0x08 queue page frame, 0x0C queue size, 0x0E queue selector, 0x10 queue kick, 0x12 device status, 0x13 interrupt status, and from 0x14 the device-specific area.

Top module: `vq_regfile_top`

## Requirements
- R1: A read of offset 0x00 returns host_feat_i OR bit 24 (empty-notify) OR bit 30 (bad-feature marker) on rd_data_o, with rd_valid_o high, in the cycle after the access. Writes to 0x00 change nothing.
- R2: A write to 0x04 with bit 30 set stores min_feat_i. Otherwise, a write that asks for any bit outside (host_feat_i OR bit 24) stores that full host set. Otherwise the written word is stored. The stored word reads back at 0x04 and appears on guest_feat_o.
- R3: A nonzero write to 0x08 stores the page frame for the selected queue, which reads back at 0x08. The queue's ring bases then become: desc = frame·4096, avail = desc + 16·Q_SIZE, used = (avail + 4 + 2·Q_SIZE) rounded up to a multiple of 4096. A queue with frame 0 shows all three bases as 0.
- R4: A write of 0 to 0x08 pulses dev_reset_o for one cycle and clears all state as in R7.
- R5: A write to 0x0E keeps the low 16 bits and is accepted only when that value is below NQ. Otherwise the previous selection stays. The selection reads back at 0x0E.
- R6: A write of n to 0x10 pulses bit n of q_notify_o for one cycle, but only when n < NQ and queue n has a nonzero frame. Any other value produces no pulse.
- R7: A write to 0x12 stores its low 8 bits. A value of 0 pulses dev_reset_o and clears the accepted features, the selector, the status, the interrupt status and every queue frame.
- R8: drv_ready_o pulses for one cycle when a status write sets bit 2 while the stored status has bit 2 clear.
- R9: Bits on isr_set_i are ORed into the interrupt status. irq_o is high while that status is nonzero. A read of 0x13 returns the status and clears it, and irq_o is low in the following cycle.
- R10: A read from an offset below 0x14 that names no readable register (for example 0x10) returns 0xFFFFFFFF. Writes to such offsets have no effect.
- R11: An access at offset 0x14 or above raises cfg_req_o in the same cycle. cfg_addr_o carries the offset minus 0x14, and cfg_we_o and cfg_wdata_o carry the access. A read returns cfg_rdata_i in the next cycle.
- R12: A read of 0x0C returns Q_SIZE in the low 16 bits and zero above.
- R13: After rst_ni the accepted features, the selector, the status, the interrupt status, irq_o and all ring bases are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe, one beat |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | REG_AW | Byte offset in the window |
| acc_wdata_i | input | 32 | Write data, right-aligned |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read |
| rd_data_o | output | 32 | Read data |
| host_feat_i | input | 32 | Feature mask the device offers |
| min_feat_i | input | 32 | Fallback feature set |
| guest_feat_o | output | 32 | Accepted feature word |
| cfg_req_o | output | 1 | Device-specific access strobe |
| cfg_we_o | output | 1 | Device-specific write enable |
| cfg_addr_o | output | REG_AW | Offset within the device-specific area |
| cfg_wdata_o | output | 32 | Device-specific write data |
| cfg_rdata_i | input | 32 | Device-specific read data, same cycle |
| isr_set_i | input | 8 | Interrupt cause bits to set |
| irq_o | output | 1 | Interrupt line |
| dev_reset_o | output | 1 | Device reset pulse |
| drv_ready_o | output | 1 | Driver-ready pulse |
| q_notify_o | output | NQ | Per-queue kick pulses |
| q_desc_base_o | output | NQ·AW | Descriptor table bases, queue 0 in the low slice |
| q_avail_base_o | output | NQ·AW | Available ring bases |
| q_used_base_o | output | NQ·AW | Used ring bases |

## Verification
Most state in this block lives in a handful of flops, so a corrupt value reaches the ports on the next read of the matching offset.

- A wrong selector shows up immediately as a page frame stored into the wrong queue. That error is visible on the ring base outputs in the cycle after the frame write.
- A stale status byte shows up as a missing or repeated driver-ready pulse on the next status write.
- A stuck interrupt status byte keeps irq_o high one cycle after the clearing read.

Because the ring bases are derived from the frame without a register stage, any mistake in the offset arithmetic is visible as soon as the frame is written.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam int unsigned OFF_HOST_FEAT  = 'h00;
  localparam int unsigned OFF_GUEST_FEAT = 'h04;
  localparam int unsigned OFF_PFN        = 'h08;
  localparam int unsigned OFF_QSIZE      = 'h0C;
  localparam int unsigned OFF_QSEL       = 'h0E;
  localparam int unsigned OFF_NOTIFY     = 'h10;
  localparam int unsigned OFF_STATUS     = 'h12;
  localparam int unsigned OFF_ISR        = 'h13;
  localparam int unsigned OFF_DEVCFG     = 'h14;

  localparam int unsigned FEAT_EMPTY_NOTIFY = 24;
  localparam int unsigned FEAT_BAD          = 30;
  localparam int unsigned ST_DRV_OK         = 2;
  localparam int unsigned PAGE_SHIFT        = 12;
  localparam int unsigned ISR_W             = 8;

  typedef enum logic [3:0] {
    REG_HOST, REG_GUEST, REG_PFN, REG_QSIZE, REG_QSEL,
    REG_NOTIFY, REG_STATUS, REG_ISR, REG_DEVCFG, REG_NONE
  } reg_sel_e;
endpackage

// File: rtl/vq_addr_dec.sv
module vq_addr_dec #(
  parameter int unsigned REG_AW = 8
) (
  input  logic [REG_AW-1:0] addr_i,
  output vq_pkg::reg_sel_e  sel_o,
  output logic [REG_AW-1:0] cfg_off_o
);
  import vq_pkg::*;

  always_comb begin
    cfg_off_o = addr_i - REG_AW'(OFF_DEVCFG);
    if (addr_i >= REG_AW'(OFF_DEVCFG)) begin
      sel_o = REG_DEVCFG;
    end else begin
      case (addr_i)
        REG_AW'(OFF_HOST_FEAT):  sel_o = REG_HOST;
        REG_AW'(OFF_GUEST_FEAT): sel_o = REG_GUEST;
        REG_AW'(OFF_PFN):        sel_o = REG_PFN;
        REG_AW'(OFF_QSIZE):      sel_o = REG_QSIZE;
        REG_AW'(OFF_QSEL):       sel_o = REG_QSEL;
        REG_AW'(OFF_NOTIFY):     sel_o = REG_NOTIFY;
        REG_AW'(OFF_STATUS):     sel_o = REG_STATUS;
        REG_AW'(OFF_ISR):        sel_o = REG_ISR;
        default:                 sel_o = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vq_feat_neg.sv
module vq_feat_neg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] host_feat_i,
  input  logic [31:0] min_feat_i,
  output logic [31:0] host_rd_o,
  output logic [31:0] guest_o
);
  import vq_pkg::*;

  logic [31:0] host_full;
  logic [31:0] guest_q;

  assign host_full = host_feat_i | (32'd1 << FEAT_EMPTY_NOTIFY);
  assign host_rd_o = host_full | (32'd1 << FEAT_BAD);
  assign guest_o   = guest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guest_q <= '0;
    end else if (clr_i) begin
      guest_q <= '0;
    end else if (wr_i) begin
      if (wdata_i[FEAT_BAD])                  guest_q <= min_feat_i;
      else if (|(wdata_i & ~host_full))       guest_q <= host_full;
      else                                    guest_q <= wdata_i;
    end
  end
endmodule

// File: rtl/vq_ring_slot.sv
module vq_ring_slot #(
  parameter int unsigned PFN_W  = 32,
  parameter int unsigned Q_SIZE = 128,
  localparam int unsigned AW    = PFN_W + vq_pkg::PAGE_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [PFN_W-1:0] pfn_i,
  output logic [PFN_W-1:0] pfn_o,
  output logic [AW-1:0]    desc_o,
  output logic [AW-1:0]    avail_o,
  output logic [AW-1:0]    used_o
);
  import vq_pkg::*;

  localparam int unsigned PAGE_BYTES  = 1 << PAGE_SHIFT;
  localparam int unsigned DESC_BYTES  = 16 * Q_SIZE;
  localparam int unsigned AVAIL_BYTES = 4 + 2 * Q_SIZE;

  logic [PFN_W-1:0] pfn_q;
  logic [AW-1:0]    desc_w, avail_w, used_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pfn_q <= '0;
    else if (clr_i)  pfn_q <= '0;
    else if (load_i) pfn_q <= pfn_i;
  end

  // bases derived from the frame, no extra storage
  assign desc_w   = AW'(pfn_q) << PAGE_SHIFT;
  assign avail_w  = desc_w + AW'(DESC_BYTES);
  assign used_raw = avail_w + AW'(AVAIL_BYTES + PAGE_BYTES - 1);

  always_comb begin
    pfn_o = pfn_q;
    if (pfn_q == '0) begin
      desc_o  = '0;
      avail_o = '0;
      used_o  = '0;
    end else begin
      desc_o  = desc_w;
      avail_o = avail_w;
      used_o  = {used_raw[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/vq_isr_ctl.sv
module vq_isr_ctl #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] isr_o,
  output logic         irq_o
);
  logic [W-1:0] isr_q, isr_d;
  logic         irq_q;

  // new causes arriving with a clear survive it
  assign isr_d = (clr_i ? '0 : isr_q) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      irq_q <= |isr_d;
    end
  end

  assign isr_o = isr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/vq_regfile_top.sv
module vq_regfile_top #(
  parameter int unsigned NQ     = 3,
  parameter int unsigned Q_SIZE = 128,
  parameter int unsigned PFN_W  = 32,
  parameter int unsigned REG_AW = 8,
  localparam int unsigned AW    = PFN_W + vq_pkg::PAGE_SHIFT,
  localparam int unsigned SEL_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic                acc_we_i,
  input  logic [REG_AW-1:0]   acc_addr_i,
  input  logic [31:0]         acc_wdata_i,
  output logic                rd_valid_o,
  output logic [31:0]         rd_data_o,
  input  logic [31:0]         host_feat_i,
  input  logic [31:0]         min_feat_i,
  output logic [31:0]         guest_feat_o,
  output logic                cfg_req_o,
  output logic                cfg_we_o,
  output logic [REG_AW-1:0]   cfg_addr_o,
  output logic [31:0]         cfg_wdata_o,
  input  logic [31:0]         cfg_rdata_i,
  input  logic [7:0]          isr_set_i,
  output logic                irq_o,
  output logic                dev_reset_o,
  output logic                drv_ready_o,
  output logic [NQ-1:0]       q_notify_o,
  output logic [NQ*AW-1:0]    q_desc_base_o,
  output logic [NQ*AW-1:0]    q_avail_base_o,
  output logic [NQ*AW-1:0]    q_used_base_o
);
  import vq_pkg::*;

  reg_sel_e          rsel;
  logic [REG_AW-1:0] cfg_off;
  logic              acc_wr, acc_rd;
  logic              wr_guest, wr_pfn, wr_sel, wr_notify, wr_status;
  logic              soft_rst, isr_clr, ready_d;
  logic [31:0]       host_rd;
  logic [ISR_W-1:0]  isr;
  logic [SEL_W-1:0]  sel_q;
  logic [7:0]        status_q;
  logic [PFN_W-1:0]  slot_pfn [NQ];
  logic [NQ-1:0]     notify_d;
  logic [31:0]       rd_mux;
  logic              rd_valid_q, reset_q, ready_q;
  logic [31:0]       rd_data_q;
  logic [NQ-1:0]     notify_q;

  vq_addr_dec #(.REG_AW(REG_AW)) u_dec (
    .addr_i    (acc_addr_i),
    .sel_o     (rsel),
    .cfg_off_o (cfg_off)
  );

  assign acc_wr    = acc_valid_i &&  acc_we_i;
  assign acc_rd    = acc_valid_i && !acc_we_i;
  assign wr_guest  = acc_wr && (rsel == REG_GUEST);
  assign wr_pfn    = acc_wr && (rsel == REG_PFN);
  assign wr_sel    = acc_wr && (rsel == REG_QSEL);
  assign wr_notify = acc_wr && (rsel == REG_NOTIFY);
  assign wr_status = acc_wr && (rsel == REG_STATUS);

  assign soft_rst = (wr_status && (acc_wdata_i[7:0] == 8'h00))
                 || (wr_pfn && (acc_wdata_i[PFN_W-1:0] == '0));
  assign isr_clr  = soft_rst || (acc_rd && (rsel == REG_ISR));
  assign ready_d  = wr_status && acc_wdata_i[ST_DRV_OK] && !status_q[ST_DRV_OK];

  vq_feat_neg u_feat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst),
    .wr_i        (wr_guest),
    .wdata_i     (acc_wdata_i),
    .host_feat_i (host_feat_i),
    .min_feat_i  (min_feat_i),
    .host_rd_o   (host_rd),
    .guest_o     (guest_feat_o)
  );

  vq_isr_ctl #(.W(ISR_W)) u_isr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (isr_clr),
    .set_i  (isr_set_i),
    .isr_o  (isr),
    .irq_o  (irq_o)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    vq_ring_slot #(.PFN_W(PFN_W), .Q_SIZE(Q_SIZE)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (soft_rst),
      .load_i  (wr_pfn && !soft_rst && (sel_q == SEL_W'(q))),
      .pfn_i   (acc_wdata_i[PFN_W-1:0]),
      .pfn_o   (slot_pfn[q]),
      .desc_o  (q_desc_base_o[q*AW +: AW]),
      .avail_o (q_avail_base_o[q*AW +: AW]),
      .used_o  (q_used_base_o[q*AW +: AW])
    );
    // kick only queues that have a ring
    assign notify_d[q] = wr_notify && (acc_wdata_i[15:0] == 16'(q))
                      && (slot_pfn[q] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      status_q <= '0;
    end else if (soft_rst) begin
      sel_q    <= '0;
      status_q <= '0;
    end else begin
      if (wr_sel && (acc_wdata_i[15:0] < 16'(NQ))) sel_q <= acc_wdata_i[SEL_W-1:0];
      if (wr_status) status_q <= acc_wdata_i[7:0];
    end
  end

  always_comb begin
    case (rsel)
      REG_HOST:   rd_mux = host_rd;
      REG_GUEST:  rd_mux = guest_feat_o;
      REG_PFN:    rd_mux = 32'(slot_pfn[sel_q]);
      REG_QSIZE:  rd_mux = {16'h0, 16'(Q_SIZE)};
      REG_QSEL:   rd_mux = {16'h0, 16'(sel_q)};
      REG_STATUS: rd_mux = {24'h0, status_q};
      REG_ISR:    rd_mux = {24'h0, isr};
      REG_DEVCFG: rd_mux = cfg_rdata_i;
      default:    rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      reset_q    <= 1'b0;
      ready_q    <= 1'b0;
      notify_q   <= '0;
    end else begin
      rd_valid_q <= acc_rd;
      if (acc_rd) rd_data_q <= rd_mux;
      reset_q    <= soft_rst;
      ready_q    <= ready_d && !soft_rst;
      notify_q   <= notify_d;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign dev_reset_o = reset_q;
  assign drv_ready_o = ready_q;
  assign q_notify_o  = notify_q;

  assign cfg_req_o   = acc_valid_i && (rsel == REG_DEVCFG);
  assign cfg_we_o    = acc_we_i;
  assign cfg_addr_o  = cfg_off;
  assign cfg_wdata_o = acc_wdata_i;
endmodule

// File: rtl/vq_regfile_chk.sv
module vq_regfile_chk #(
  parameter int unsigned NQ     = 3,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned REG_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_we_i,
  input logic [REG_AW-1:0] acc_addr_i,
  input logic [31:0]       acc_wdata_i,
  input logic              rd_valid_o,
  input logic [31:0]       rd_data_o,
  input logic [31:0]       guest_feat_o,
  input logic [7:0]        isr_set_i,
  input logic              irq_o,
  input logic              dev_reset_o,
  input logic              drv_ready_o,
  input logic [NQ-1:0]     q_notify_o,
  input logic [SEL_W-1:0]  sel_i,
  input logic [7:0]        status_i
);
  import vq_pkg::*;

  logic rd_acc, wr_acc;
  assign rd_acc = acc_valid_i && !acc_we_i;
  assign wr_acc = acc_valid_i &&  acc_we_i;

  assert_host_rd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc && acc_addr_i == REG_AW'(OFF_HOST_FEAT)
    |=> rd_valid_o && rd_data_o[FEAT_BAD] && rd_data_o[FEAT_EMPTY_NOTIFY]);

  assert_pfn_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && acc_addr_i == REG_AW'(OFF_PFN) && acc_wdata_i == 32'h0
    |=> dev_reset_o && guest_feat_o == 32'h0);

  assert_sel_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_i) < NQ);

  assert_sel_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && acc_addr_i == REG_AW'(OFF_QSEL) && 32'(acc_wdata_i[15:0]) >= NQ
    |=> $stable(sel_i));

  assert_notify_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q_notify_o));

  assert_status_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && acc_addr_i == REG_AW'(OFF_STATUS) && acc_wdata_i[7:0] == 8'h0
    |=> dev_reset_o && status_i == 8'h0 && sel_i == '0);

  assert_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && acc_addr_i == REG_AW'(OFF_STATUS) && acc_wdata_i[ST_DRV_OK]
    && !status_i[ST_DRV_OK] |=> drv_ready_o);

  assert_isr_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc && acc_addr_i == REG_AW'(OFF_ISR) && isr_set_i == 8'h0 |=> !irq_o);

  assert_undef_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc && acc_addr_i == REG_AW'(OFF_NOTIFY) |=> rd_data_o == 32'hFFFF_FFFF);
endmodule

bind vq_regfile_top vq_regfile_chk #(.NQ(NQ), .SEL_W(SEL_W), .REG_AW(REG_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_we_i     (acc_we_i),
  .acc_addr_i   (acc_addr_i),
  .acc_wdata_i  (acc_wdata_i),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .guest_feat_o (guest_feat_o),
  .isr_set_i    (isr_set_i),
  .irq_o        (irq_o),
  .dev_reset_o  (dev_reset_o),
  .drv_ready_o  (drv_ready_o),
  .q_notify_o   (q_notify_o),
  .sel_i        (sel_q),
  .status_i     (status_q)
);

// File: tb/tb_vq_regfile_top.sv
module tb_vq_regfile_top;
  localparam int NQ = 3;
  localparam int AW = 44;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          acc_valid = 0, acc_we = 0;
  logic [7:0]    acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic [7:0]    isr_set = '0;
  logic          rd_valid, irq, dev_reset, drv_ready;
  logic [31:0]   rd_data, guest_feat, cfg_wdata, cfg_rdata;
  logic          cfg_req, cfg_we;
  logic [7:0]    cfg_addr;
  logic [NQ-1:0] q_notify;
  logic [NQ*AW-1:0] q_desc, q_avail, q_used;

  assign cfg_rdata = 32'hC0DE_0000 | {24'h0, cfg_addr};

  vq_regfile_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_we_i(acc_we), .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .host_feat_i(32'h0000_00A5), .min_feat_i(32'h0000_0001), .guest_feat_o(guest_feat),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata),
    .cfg_rdata_i(cfg_rdata), .isr_set_i(isr_set), .irq_o(irq),
    .dev_reset_o(dev_reset), .drv_ready_o(drv_ready), .q_notify_o(q_notify),
    .q_desc_base_o(q_desc), .q_avail_base_o(q_avail), .q_used_base_o(q_used)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rd_cap;
  logic rv_cap, rst_cap, rdy_cap, c_req, c_we;
  logic [NQ-1:0] ntf_cap;
  logic [7:0] c_addr;
  logic [31:0] c_wdata;

  // {we, addr, wdata, chk, expected, req}
  localparam logic [81:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,          1'b1, 32'h4100_00A5, 8'd1},  // R1
    {1'b1, 8'h04, 32'h0100_0021,  1'b0, 32'h0,         8'd2},
    {1'b0, 8'h04, 32'h0,          1'b1, 32'h0100_0021, 8'd2},  // R2 subset
    {1'b1, 8'h04, 32'h0000_0002,  1'b0, 32'h0,         8'd2},
    {1'b0, 8'h04, 32'h0,          1'b1, 32'h0100_00A5, 8'd2},  // R2 excess
    {1'b1, 8'h04, 32'h4000_0021,  1'b0, 32'h0,         8'd2},
    {1'b0, 8'h04, 32'h0,          1'b1, 32'h0000_0001, 8'd2},  // R2 bad bit
    {1'b0, 8'h0C, 32'h0,          1'b1, 32'h0000_0080, 8'd12}, // R12
    {1'b1, 8'h0E, 32'h0000_0002,  1'b0, 32'h0,         8'd5},
    {1'b0, 8'h0E, 32'h0,          1'b1, 32'h0000_0002, 8'd5},  // R5
    {1'b1, 8'h0E, 32'h0000_0003,  1'b0, 32'h0,         8'd5},
    {1'b0, 8'h0E, 32'h0,          1'b1, 32'h0000_0002, 8'd5},  // R5 reject
    {1'b1, 8'h0E, 32'h0001_0001,  1'b0, 32'h0,         8'd5},
    {1'b0, 8'h0E, 32'h0,          1'b1, 32'h0000_0001, 8'd5},  // R5 mask
    {1'b1, 8'h08, 32'h0000_0123,  1'b0, 32'h0,         8'd3},
    {1'b0, 8'h08, 32'h0,          1'b1, 32'h0000_0123, 8'd3},  // R3
    {1'b0, 8'h10, 32'h0,          1'b1, 32'hFFFF_FFFF, 8'd10}, // R10
    {1'b1, 8'h12, 32'h0000_0103,  1'b0, 32'h0,         8'd7},
    {1'b0, 8'h12, 32'h0,          1'b1, 32'h0000_0003, 8'd7}   // R7
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    #1;
    c_req = cfg_req; c_we = cfg_we; c_addr = cfg_addr; c_wdata = cfg_wdata;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
    rd_cap = rd_data; rv_cap = rd_valid; rst_cap = dev_reset;
    rdy_cap = drv_ready; ntf_cap = q_notify;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    chk("R13 irq", 64'(irq), 64'h0);
    chk("R13 bases", 64'(|{q_desc, q_avail, q_used}), 64'h0);
    acc(0, 8'h04, 0); chk("R13 guest", 64'(rd_cap), 64'h0);
    acc(0, 8'h0E, 0); chk("R13 sel", 64'(rd_cap), 64'h0);
    acc(0, 8'h12, 0); chk("R13 status", 64'(rd_cap), 64'h0);
    acc(0, 8'h13, 0); chk("R13 isr", 64'(rd_cap), 64'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][81], VEC[i][80:73], VEC[i][72:41]);
      if (VEC[i][40]) chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), 64'(rd_cap), 64'(VEC[i][39:8]));
    end

    // R1 valid flag and read-only word
    acc(1, 8'h00, 32'hFFFF_FFFF);
    acc(0, 8'h00, 0);
    chk("R1 valid", 64'(rv_cap), 64'h1);
    chk("R1 ro", 64'(rd_cap), 64'h4100_00A5);

    // R3 bases of queue 1 (frame 0x123, size 128)
    chk("R3 desc", 64'(q_desc[AW +: AW]), 64'h12_3000);
    chk("R3 avail", 64'(q_avail[AW +: AW]), 64'h12_3800);
    chk("R3 used", 64'(q_used[AW +: AW]), 64'h12_4000);
    chk("R3 q0 idle", 64'(q_desc[0 +: AW]), 64'h0);

    // R6 kicks
    acc(1, 8'h10, 32'h1); chk("R6 kick q1", 64'(ntf_cap), 64'h2);
    acc(1, 8'h10, 32'h0); chk("R6 uninit q0", 64'(ntf_cap), 64'h0);
    acc(1, 8'h10, 32'h5); chk("R6 bad index", 64'(ntf_cap), 64'h0);

    // R8 driver-ready edge
    acc(1, 8'h12, 32'h07); chk("R8 rise", 64'(rdy_cap), 64'h1);
    acc(1, 8'h12, 32'h0F); chk("R8 held", 64'(rdy_cap), 64'h0);

    // R9 interrupt status
    @(negedge clk); isr_set = 8'h01;
    @(negedge clk); isr_set = 8'h00;
    chk("R9 irq up", 64'(irq), 64'h1);
    acc(0, 8'h13, 0);
    chk("R9 value", 64'(rd_cap), 64'h01);
    chk("R9 irq down", 64'(irq), 64'h0);
    acc(0, 8'h13, 0); chk("R9 cleared", 64'(rd_cap), 64'h0);

    // R11 device-specific window
    acc(1, 8'h18, 32'hDEAD_BEEF);
    chk("R11 req", 64'({c_req, c_we}), 64'h3);
    chk("R11 addr", 64'(c_addr), 64'h4);
    chk("R11 wdata", 64'(c_wdata), 64'hDEAD_BEEF);
    acc(0, 8'h20, 0); chk("R11 rdata", 64'(rd_cap), 64'hC0DE_000C);

    // R10 write to a hole changes nothing
    acc(1, 8'h11, 32'h0000_0000);
    chk("R10 hole no reset", 64'(rst_cap), 64'h0);
    acc(0, 8'h12, 0); chk("R10 status kept", 64'(rd_cap), 64'h0F);

    // R7 status zero resets everything
    acc(1, 8'h12, 32'h0); chk("R7 pulse", 64'(rst_cap), 64'h1);
    chk("R7 q1 cleared", 64'(q_desc[AW +: AW]), 64'h0);
    acc(0, 8'h04, 0); chk("R7 guest", 64'(rd_cap), 64'h0);
    acc(0, 8'h0E, 0); chk("R7 sel", 64'(rd_cap), 64'h0);
    acc(0, 8'h12, 0); chk("R7 status", 64'(rd_cap), 64'h0);

    // R4 zero frame resets
    acc(1, 8'h04, 32'h21);
    acc(1, 8'h0E, 32'h2);
    acc(1, 8'h08, 32'h10);
    chk("R3 q2 desc", 64'(q_desc[2*AW +: AW]), 64'h1_0000);
    chk("R3 q2 used", 64'(q_used[2*AW +: AW]), 64'h1_1000);
    acc(1, 8'h08, 32'h0); chk("R4 pulse", 64'(rst_cap), 64'h1);
    chk("R4 q2 cleared", 64'(q_desc[2*AW +: AW]), 64'h0);
    acc(0, 8'h04, 0); chk("R4 guest", 64'(rd_cap), 64'h0);

    finish_run();
  end
endmodule